// File: doc/BRIEF.md
# Punched-Tape Binary Word Loader

This block loads a binary record from an 8-channel punched tape into a 4K-word memory without any processor involvement. Tape frames arrive one per handshake from a reader interface. The block skips the leading run of marker frames. It then pairs the following frames into 12-bit words, where each frame carries six payload bits. Words that carry an origin flag move the load pointer. Every other word is written to memory at consecutive addresses.

Every assembled word, including origin words, is added into a 12-bit running sum. The tape writer chooses the final word of the record so that this sum comes to zero. That final check word takes part in the sum but is never stored. To achieve this, each data word is held back by one word before it is written. A marker frame at a word boundary after data has begun ends the record. The engine then stops taking frames, raises its done flag and shows the sum residue, where zero means a clean load. A start pulse rearms the engine for another record.

Top module: `tape_loader`

## Requirements
- R1: Before data begins, every frame equal to 8'h80 (only the top channel punched) is consumed as leader: it writes nothing, leaves the sum at 0 and does not raise done.
- R2: The first frame that differs from 8'h80 begins data, and an all-zero frame counts as data. Without an origin word, loading starts at address 0.
- R3: A word is {first frame bits [5:0], second frame bits [5:0]}. Bits [7:6] of a data word's frames do not reach the stored value.
- R4: A word whose first frame has bit 6 set and bit 7 clear is an origin word. Its 12-bit value becomes the next load address, and it is never written to memory.
- R5: Data words after an origin are stored at consecutive addresses that increment by one modulo 4096, so address 4095 is followed by 0.
- R6: sum_o is the modulo-4096 sum of every assembled word since the last start, counting origin words and the check word.
- R7: An 8'h80 frame in the first-frame position after data has begun ends the record. done_o rises on the next cycle, and the last assembled data word (the check word) is never written.
- R8: Every data word except the check word is written exactly once. The write of word N shows on the write port in the cycle after the second frame of the next assembled word is accepted.
- R9: While done_o is high, frame_ready_o is low, frames are not consumed, no write occurs, and done_o and sum_o hold their values.
- R10: A start pulse clears the sum, the load address, the held-back word and done_o. frame_ready_o is low during the start cycle.
- R11: After reset, frame_ready_o is 1, and done_o, mem_we_o and sum_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that rearms the loader |
| frame_valid_i | input | 1 | Reader offers a frame |
| frame_data_i | input | 8 | Tape frame, bit 7 = top channel |
| frame_ready_o | output | 1 | Loader accepts the offered frame |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 12 | Memory write address |
| mem_wdata_o | output | 12 | Memory write data |
| done_o | output | 1 | Record ended by trailer |
| sum_o | output | 12 | Running checksum residue |

## Verification
The records swept through the bench vary in length, origin, payload pattern and junk in the upper frame bits. Some records close with a correct check word and others with a deliberately wrong one. The correct records show that the residue returns to zero. The wrong ones show that the residue equals the exact error, which rules out a sum that skips origin or check words. A record whose origin lies just below 4095 separates true wrapping from saturation. A record that starts on a blank frame separates blank tape from leader. A probe cycle by cycle around the first two words pins the one-word delay of the writes. A start pulse in the middle of a record shows that the held-back word is dropped and that the address returns to zero.

// File: rtl/tload_pkg.sv
package tload_pkg;
    localparam int FRAME_W = 8;
    localparam int HALF_W  = 6;
    localparam int WORD_W  = 2 * HALF_W;
    localparam int ADDR_W  = 12;

    typedef enum logic [1:0] {
        ST_SEEK = 2'd0,
        ST_HI   = 2'd1,
        ST_LO   = 2'd2,
        ST_DONE = 2'd3
    } ld_state_e;
endpackage

// File: rtl/tload_frame_decode.sv
module tload_frame_decode #(
    parameter int FRAME_W = tload_pkg::FRAME_W,
    parameter int HALF_W  = tload_pkg::HALF_W
) (
    input  logic [FRAME_W-1:0] frame_i,
    output logic               is_mark_o,
    output logic               is_origin_o,
    output logic [HALF_W-1:0]  payload_o
);
    localparam logic [FRAME_W-1:0] MARK = {1'b1, {(FRAME_W-1){1'b0}}};

    always_comb begin
        is_mark_o   = (frame_i == MARK);
        is_origin_o = frame_i[FRAME_W-2] && !frame_i[FRAME_W-1];
        payload_o   = frame_i[HALF_W-1:0];
    end
endmodule

// File: rtl/tload_lookahead.sv
module tload_lookahead #(
    parameter int ADDR_W = tload_pkg::ADDR_W,
    parameter int WORD_W = tload_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic [WORD_W-1:0] push_data_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WORD_W-1:0] data_o
);
    typedef struct packed {
        logic              hold_v;
        logic [ADDR_W-1:0] hold_a;
        logic [WORD_W-1:0] hold_d;
        logic              we;
        logic [ADDR_W-1:0] a;
        logic [WORD_W-1:0] d;
    } la_s;

    la_s la_d, la_q;

    always_comb begin
        la_d    = la_q;
        la_d.we = 1'b0;
        if (clear_i) begin
            la_d.hold_v = 1'b0;
        end else if (push_i) begin
            if (la_q.hold_v) begin
                la_d.we = 1'b1;
                la_d.a  = la_q.hold_a;
                la_d.d  = la_q.hold_d;
            end
            la_d.hold_v = 1'b1;
            la_d.hold_a = push_addr_i;
            la_d.hold_d = push_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) la_q <= '0;
        else        la_q <= la_d;
    end

    assign we_o   = la_q.we;
    assign addr_o = la_q.a;
    assign data_o = la_q.d;

    // R8: a write only follows a push that found an earlier word held
    p_write_needs_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> $past(push_i) && !$past(clear_i));
    // R8: a write is a single-cycle pulse per push
    p_write_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && !push_i) |=> !we_o);
    // R10: clearing drops the held word, so the next push cannot write
    p_clear_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !we_o);
endmodule

// File: rtl/tape_loader.sv
module tape_loader #(
    parameter int FRAME_W = tload_pkg::FRAME_W,
    parameter int HALF_W  = tload_pkg::HALF_W,
    parameter int ADDR_W  = tload_pkg::ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               frame_valid_i,
    input  logic [FRAME_W-1:0] frame_data_i,
    output logic               frame_ready_o,
    output logic               mem_we_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [2*HALF_W-1:0] mem_wdata_o,
    output logic               done_o,
    output logic [2*HALF_W-1:0] sum_o
);
    import tload_pkg::*;

    localparam int WORD_W = 2 * HALF_W;

    typedef struct packed {
        ld_state_e         st;
        logic [HALF_W-1:0] hi;
        logic              org;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] sum;
    } core_s;

    core_s c_d, c_q;

    logic              f_mark, f_org;
    logic [HALF_W-1:0] f_pay;
    logic              accept;
    logic              push;
    logic [WORD_W-1:0] word;

    tload_frame_decode #(.FRAME_W(FRAME_W), .HALF_W(HALF_W)) u_decode (
        .frame_i     (frame_data_i),
        .is_mark_o   (f_mark),
        .is_origin_o (f_org),
        .payload_o   (f_pay)
    );

    assign frame_ready_o = (c_q.st != ST_DONE) && !start_i;
    assign accept        = frame_valid_i && frame_ready_o;
    assign word          = {c_q.hi, f_pay};

    always_comb begin
        c_d  = c_q;
        push = 1'b0;
        if (start_i) begin
            c_d.st   = ST_SEEK;
            c_d.sum  = '0;
            c_d.addr = '0;
            c_d.org  = 1'b0;
        end else if (accept) begin
            unique case (c_q.st)
                ST_SEEK, ST_HI: begin
                    if (f_mark) begin
                        if (c_q.st == ST_HI) c_d.st = ST_DONE;
                    end else begin
                        c_d.hi  = f_pay;
                        c_d.org = f_org;
                        c_d.st  = ST_LO;
                    end
                end
                ST_LO: begin
                    c_d.sum = c_q.sum + word;
                    c_d.st  = ST_HI;
                    if (c_q.org) begin
                        c_d.addr = word[ADDR_W-1:0];
                    end else begin
                        push     = 1'b1;
                        c_d.addr = c_q.addr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_SEEK;
        end else begin
            c_q <= c_d;
        end
    end

    tload_lookahead #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_lookahead (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start_i),
        .push_i      (push),
        .push_addr_i (c_q.addr),
        .push_data_i (word),
        .we_o        (mem_we_o),
        .addr_o      (mem_addr_o),
        .data_o      (mem_wdata_o)
    );

    assign done_o = (c_q.st == ST_DONE);
    assign sum_o  = c_q.sum;

    // R9: a finished engine refuses frames
    p_no_ready_when_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !frame_ready_o);
    // R9: result holds until the next start
    p_result_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(sum_o)));
    // R7: the check word is never written once the trailer is seen
    p_no_write_after_trailer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_we_o);
    // R10: start clears result state
    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (sum_o == '0 && !done_o));
    // R1: leader before data leaves the sum alone
    p_leader_no_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_SEEK && !start_i) |=> $stable(sum_o));
endmodule

// File: tb/tape_loader_bench.sv
module tape_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        frame_valid_i = 1'b0;
    logic [7:0]  frame_data_i = 8'h00;
    logic        frame_ready_o, mem_we_o, done_o;
    logic [11:0] mem_addr_o, mem_wdata_o, sum_o;

    always #2 clk = ~clk;

    tape_loader u_tape_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .frame_valid_i(frame_valid_i), .frame_data_i(frame_data_i),
        .frame_ready_o(frame_ready_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .done_o(done_o), .sum_o(sum_o)
    );

    int errs = 0;
    int checks = 0;
    int log_n = 0;
    logic [11:0] log_a [0:63];
    logic [11:0] log_d [0:63];
    logic [11:0] words [0:15];

    always @(negedge clk) begin
        if (mem_we_o) begin
            if (log_n < 64) begin
                log_a[log_n] = mem_addr_o;
                log_d[log_n] = mem_wdata_o;
            end
            log_n = log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] f);
        frame_valid_i = 1'b1;
        frame_data_i  = f;
        @(negedge clk);
        frame_valid_i = 1'b0;
    endtask

    task automatic send_word(input logic [11:0] w, input bit org);
        if (org) send({2'b01, w[11:6]});
        else     send({2'b11, w[11:6]});
        send({2'b11, w[5:0]});
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        #1;
        chk(frame_ready_o == 1'b0, "R10 ready low in start cycle", frame_ready_o, 0);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_record(input logic [11:0] org, input int n, input int seed,
                              input logic [11:0] bad);
        logic [11:0] s;
        pulse_start();
        log_n = 0;
        repeat (3) send(8'h80);
        chk(sum_o == 0 && log_n == 0 && !done_o, "R1 leader ignored", sum_o, 0);
        send_word(org, 1'b1);
        s = org;
        for (int i = 0; i < n; i++) begin
            words[i] = 12'((i * 677 + seed * 1031 + 5) & 12'hFFF);
            send_word(words[i], 1'b0);
            s = s + words[i];
        end
        send_word(12'(-s) + bad, 1'b0);
        send(8'h80);
        chk(done_o == 1'b1, "R7 done after trailer", done_o, 1);
        chk(sum_o == bad, "R6 checksum residue", sum_o, bad);
        chk(log_n == n, "R8 write count excludes check word", log_n, n);
        for (int i = 0; i < n; i++) begin
            chk(log_a[i] == 12'(org + i), "R5 consecutive address", log_a[i], 12'(org + i));
            chk(log_d[i] == words[i], "R3 assembled word", log_d[i], words[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [11:0] keep;
        repeat (2) @(negedge clk);
        // R11 reset state
        chk(frame_ready_o == 1 && done_o == 0 && mem_we_o == 0 && sum_o == 0,
            "R11 reset state", {frame_ready_o, done_o, mem_we_o}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5 R6 sweep over lengths, origins and errors
        for (int seed = 0; seed < 12; seed++)
            run_record(12'((seed * 331) & 12'hFFF), seed % 7 + 1, seed,
                       (seed % 4 == 3) ? 12'(seed * 9) : 12'h000);
        // R5 wrap at top of field
        run_record(12'd4094, 4, 3, 12'h000);

        // R9 frames after done
        keep = sum_o;
        frame_valid_i = 1'b1;
        frame_data_i  = 8'h41;
        repeat (3) @(negedge clk);
        frame_valid_i = 1'b0;
        chk(frame_ready_o == 0 && done_o == 1, "R9 ready low while done", frame_ready_o, 0);
        chk(sum_o == keep, "R9 sum held", sum_o, keep);
        chk(log_n == 4, "R9 no write while done", log_n, 4);

        // R2 blank start loads at address 0
        pulse_start();
        log_n = 0;
        send(8'h00);
        send(8'h05);
        send_word(12'h123, 1'b0);
        send_word(12'(-(12'h005 + 12'h123)), 1'b0);
        send(8'h80);
        chk(log_n == 2, "R2 blank frame is data", log_n, 2);
        chk(log_a[0] == 0 && log_d[0] == 12'h005, "R2 first word at address 0", log_d[0], 5);
        chk(log_a[1] == 1 && log_d[1] == 12'h123, "R2 second word", log_d[1], 12'h123);
        chk(sum_o == 0, "R6 blank record sum", sum_o, 0);

        // R8 lookahead timing
        pulse_start();
        log_n = 0;
        send_word(12'h777, 1'b0);
        chk(mem_we_o == 0, "R8 first word held back", mem_we_o, 0);
        repeat (2) @(negedge clk);
        chk(log_n == 0, "R8 no write while only one word", log_n, 0);
        send_word(12'h111, 1'b0);
        chk(mem_we_o == 1 && mem_addr_o == 0 && mem_wdata_o == 12'h777,
            "R8 write follows next word", mem_wdata_o, 12'h777);

        // R10 start mid-record drops held word and resets address
        pulse_start();
        @(negedge clk);
        chk(log_n == 1, "R10 held word dropped", log_n, 1);
        chk(sum_o == 0 && done_o == 0, "R10 sum and done cleared", sum_o, 0);
        log_n = 0;
        send_word(12'h222, 1'b0);
        send_word(12'h333, 1'b0);
        send_word(12'(-(12'h222 + 12'h333)), 1'b0);
        send(8'h80);
        chk(log_n == 2 && log_a[0] == 0 && log_d[0] == 12'h222,
            "R10 address cleared", log_a[0], 0);
        chk(sum_o == 0 && done_o == 1, "R7 record closed", sum_o, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule